// File: doc/BRIEF.md
# Variable-Width High-Half Multiplier

This unit returns the upper half of a product when the two source elements need not be the same width. Each source carries its own width code (8, 16 or 32 bits), and so does the destination. The extraction point is not a fixed register width. The full product is shifted down by the larger of the two source widths. The piece that remains is then widened or cut to fit the destination element.

Three signedness modes are offered: both sources signed, the first signed and the second unsigned, and both unsigned. Each source is taken from the low bits of its input bus and extended from its own width according to its signedness.

One request is accepted per cycle, qualified by `in_valid`. The result appears, registered, one cycle later with `out_valid`.

Top module: `mulh_varwidth`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, so the latency is one clock. After reset `out_valid` is 0 and `dest` is 0.
- R2: Width codes are 2'b00 = 8 bits, 2'b01 = 16 bits and 2'b10 = 32 bits. Each source uses only the low bits of its bus that its width selects, and input bits above that width have no effect on `dest`.
- R3: `op_sel` 2'b00 treats both sources as signed. 2'b01 treats `src_a` as signed and `src_b` as unsigned. 2'b10 treats both as unsigned.
- R4: With M the larger of the two source widths, the high part is bits [2M-1:M] of the full product of the extended sources.
- R5: For `op_sel` 2'b00 and 2'b01, the M-bit high part is sign-extended from bit M-1 up to the destination width. For 2'b10 it is zero-extended.
- R6: When the destination width is smaller than M, the upper bits of the high part are dropped, with no flag.
- R7: Bits of `dest` at and above the destination width are zero.
- R8: If any width code is 2'b11, or `op_sel` is 2'b11, the result is zero.
- R9: In a cycle with `in_valid` low, `dest` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for the current inputs |
| op_sel | input | 2 | Signedness mode |
| a_width | input | 2 | Width code of `src_a` |
| b_width | input | 2 | Width code of `src_b` |
| d_width | input | 2 | Width code of the destination element |
| src_a | input | 32 | First source, taken from the low bits |
| src_b | input | 32 | Second source, taken from the low bits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dest | output | 32 | Destination element, zero above its width |

## Verification
The assertions assume that `in_valid` and the request fields are known at every rising edge once reset is released. They also assume that `in_valid` is low while reset is asserted, so that the latency and hold properties begin on clean history. The bench changes inputs only on falling edges and holds `in_valid` low during reset. It mixes reserved codes and junk upper source bits into the random requests, so that the zero-result and ignore properties are reached without ever presenting an unknown value.

// File: rtl/mulh_pkg.sv
package mulh_pkg;
  localparam int ELEM_W = 32;
  localparam int CNT_W  = $clog2(ELEM_W) + 1;
  localparam int IDX_W  = $clog2(ELEM_W);
  localparam int PROD_W = 2 * ELEM_W + 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    MODE_SS  = 2'b00,
    MODE_SU  = 2'b01,
    MODE_UU  = 2'b10,
    MODE_RSV = 2'b11
  } mode_t;

  // Width code to bit count; reserved code yields zero bits.
  function automatic cnt_t code_bits(input logic [1:0] code);
    case (code)
      2'b00:   return cnt_t'(8);
      2'b01:   return cnt_t'(16);
      2'b10:   return cnt_t'(32);
      default: return cnt_t'(0);
    endcase
  endfunction

  function automatic cnt_t wider(input cnt_t x, input cnt_t y);
    return (x > y) ? x : y;
  endfunction

  // Index of the top bit of a field of the given bit count.
  function automatic logic [IDX_W-1:0] top_idx(input cnt_t n);
    cnt_t t;
    t = n - cnt_t'(1);
    return t[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/mulh_operand_ext.sv
module mulh_operand_ext
  import mulh_pkg::*;
(
  input  logic [ELEM_W-1:0]  raw,
  input  logic [1:0]         code,
  input  logic               as_signed,
  output logic signed [ELEM_W:0] ext,
  output cnt_t               bits
);
  logic fill;

  always_comb begin
    bits = code_bits(code);
    fill = as_signed && (bits != '0) && raw[top_idx(bits)];
    for (int i = 0; i <= ELEM_W; i++) begin
      if (i < int'(bits)) ext[i] = raw[i];
      else                ext[i] = fill;
    end
  end
endmodule

// File: rtl/mulh_high_extract.sv
module mulh_high_extract
  import mulh_pkg::*;
(
  input  logic signed [ELEM_W:0] a_ext,
  input  logic signed [ELEM_W:0] b_ext,
  input  cnt_t                   shift,
  output logic [ELEM_W-1:0]      hi,
  output logic                   hi_msb
);
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    prod    = PROD_W'(a_ext) * PROD_W'(b_ext);
    shifted = prod >>> shift;
    hi      = shifted[ELEM_W-1:0];
    hi_msb  = (shift != '0) ? shifted[top_idx(shift)] : 1'b0;
  end
endmodule

// File: rtl/mulh_dest_fit.sv
module mulh_dest_fit
  import mulh_pkg::*;
(
  input  logic [ELEM_W-1:0] hi,
  input  logic              hi_msb,
  input  cnt_t              src_bits,
  input  cnt_t              dst_bits,
  input  logic              sext,
  output logic [ELEM_W-1:0] fitted
);
  always_comb begin
    for (int i = 0; i < ELEM_W; i++) begin
      if (i >= int'(dst_bits))      fitted[i] = 1'b0;
      else if (i < int'(src_bits))  fitted[i] = hi[i];
      else                          fitted[i] = sext & hi_msb;
    end
  end
endmodule

// File: rtl/mulh_varwidth.sv
module mulh_varwidth
  import mulh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        a_width,
  input  logic [1:0]        b_width,
  input  logic [1:0]        d_width,
  input  logic [31:0]       src_a,
  input  logic [31:0]       src_b,
  output logic              out_valid,
  output logic [31:0]       dest
);
  localparam int NSRC = 2;

  logic [ELEM_W-1:0]      raw_arr  [NSRC];
  logic [1:0]             code_arr [NSRC];
  logic                   sgn_arr  [NSRC];
  logic signed [ELEM_W:0] ext_arr  [NSRC];
  cnt_t                   bits_arr [NSRC];

  mode_t             mode;
  cnt_t              max_src_bits;
  cnt_t              dst_bits;
  logic              reserved_hit;
  logic [ELEM_W-1:0] hi_part;
  logic              hi_sign;
  logic [ELEM_W-1:0] fit_out;

  assign mode        = mode_t'(op_sel);
  assign raw_arr[0]  = src_a;
  assign raw_arr[1]  = src_b;
  assign code_arr[0] = a_width;
  assign code_arr[1] = b_width;
  assign sgn_arr[0]  = (mode == MODE_SS) || (mode == MODE_SU);
  assign sgn_arr[1]  = (mode == MODE_SS);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    mulh_operand_ext u_ext (
      .raw       (raw_arr[g]),
      .code      (code_arr[g]),
      .as_signed (sgn_arr[g]),
      .ext       (ext_arr[g]),
      .bits      (bits_arr[g])
    );
  end

  assign max_src_bits = wider(bits_arr[0], bits_arr[1]);
  assign dst_bits     = code_bits(d_width);
  assign reserved_hit = (mode == MODE_RSV) || (bits_arr[0] == '0) ||
                        (bits_arr[1] == '0) || (dst_bits == '0);

  mulh_high_extract u_hi (
    .a_ext  (ext_arr[0]),
    .b_ext  (ext_arr[1]),
    .shift  (max_src_bits),
    .hi     (hi_part),
    .hi_msb (hi_sign)
  );

  mulh_dest_fit u_fit (
    .hi       (hi_part),
    .hi_msb   (hi_sign),
    .src_bits (max_src_bits),
    .dst_bits (dst_bits),
    .sext     (mode != MODE_UU),
    .fitted   (fit_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dest      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dest <= reserved_hit ? '0 : fit_out;
    end
  end
endmodule

// File: rtl/mulh_varwidth_chk.sv
module mulh_varwidth_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op_sel,
  input logic [1:0]  a_width,
  input logic [1:0]  b_width,
  input logic [1:0]  d_width,
  input logic        out_valid,
  input logic [31:0] dest,
  input logic        reserved_hit
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && reserved_hit) |=> (dest == 32'd0));

  assert_dest8_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && d_width == 2'b00) |=> (dest[31:8] == 24'd0));

  assert_dest16_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && d_width == 2'b01) |=> (dest[31:16] == 16'd0));

  assert_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b10 && a_width == 2'b00 && b_width == 2'b00 &&
     d_width == 2'b10) |=> (dest[31:8] == 24'd0));

  assert_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 2'b00 || op_sel == 2'b01) && a_width == 2'b00 &&
     b_width == 2'b00 && d_width == 2'b10) |=> (dest[31:8] == {24{dest[7]}}));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dest));
endmodule

bind mulh_varwidth mulh_varwidth_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_sel       (op_sel),
  .a_width      (a_width),
  .b_width      (b_width),
  .d_width      (d_width),
  .out_valid    (out_valid),
  .dest         (dest),
  .reserved_hit (reserved_hit)
);

// File: tb/test_mulh_varwidth.sv
`timescale 1ns/1ps
module test_mulh_varwidth;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [1:0]  a_width = 2'b00;
  logic [1:0]  b_width = 2'b00;
  logic [1:0]  d_width = 2'b00;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic [31:0] dest;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mulh_varwidth i_mulh_varwidth (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .a_width(a_width), .b_width(b_width), .d_width(d_width),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .dest(dest)
  );

  // Model: extend, multiply wide, arithmetic shift by the larger width, mask.
  function automatic logic [31:0] model(input logic [1:0] op, input logic [1:0] wa,
      input logic [1:0] wb, input logic [1:0] wd, input logic [31:0] a, input logic [31:0] b);
    int ma, mb, m, md;
    logic signed [65:0] ae, be, pr, sh;
    logic [63:0] mask;
    if (op == 2'b11 || wa == 2'b11 || wb == 2'b11 || wd == 2'b11) return 32'd0;
    ma = 8 << wa; mb = 8 << wb; md = 8 << wd;
    m  = (ma > mb) ? ma : mb;
    mask = (64'd1 << ma) - 64'd1;
    ae = $signed({2'b00, 64'(a) & mask});
    if (op != 2'b10 && a[ma-1]) ae = ae - (66'sd1 <<< ma);
    mask = (64'd1 << mb) - 64'd1;
    be = $signed({2'b00, 64'(b) & mask});
    if (op == 2'b00 && b[mb-1]) be = be - (66'sd1 <<< mb);
    pr = ae * be;
    sh = pr >>> m;
    mask = (64'd1 << md) - 64'd1;
    return sh[31:0] & mask[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [1:0] wa, input logic [1:0] wb,
      input logic [1:0] wd, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] exp, input string req);
    @(negedge clk);
    op_sel = op; a_width = wa; b_width = wb; d_width = wd;
    src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R1 valid", {31'd0, out_valid}, 32'd1);
    check(dest === exp, req, dest, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && dest === 32'd0, "R1 reset", dest, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 8x8 signed: 0x80*0x80 = 0x4000, high byte 0x40
    apply(2'b00, 2'b00, 2'b00, 2'b10, 32'h80, 32'h80, 32'h40, "R4 8x8");
    // R5 signed -1*1 -> high part 0xFF sign-extended
    apply(2'b00, 2'b00, 2'b00, 2'b10, 32'hFF, 32'h01, 32'hFFFF_FFFF, "R5 sext");
    // R3 R5 unsigned 0xFF*0xFF = 0xFE01 -> 0xFE zero-extended
    apply(2'b10, 2'b00, 2'b00, 2'b10, 32'hFF, 32'hFF, 32'h0000_00FE, "R3 R5 zext");
    // R3 mixed: signed -1 (8b) * unsigned 0xFF -> -255 -> high 0xFF, sext
    apply(2'b01, 2'b00, 2'b00, 2'b10, 32'hFF, 32'hFF, 32'hFFFF_FFFF, "R3 mixed");
    // R4 16x8 unsigned: 0xFFFF*0xFF = 0xFEFF01 >> 16 = 0xFE
    apply(2'b10, 2'b01, 2'b00, 2'b10, 32'hFFFF, 32'hFF, 32'h0000_00FE, "R4 16x8");
    // R4 32x8 unsigned: 0xFFFFFFFF*0xFF >> 32 = 0xFE
    apply(2'b10, 2'b10, 2'b00, 2'b10, 32'hFFFF_FFFF, 32'hFF, 32'h0000_00FE, "R4 32x8");
    // R6 truncation: 32x32 unsigned high = 0xFFFFFFFE, dest 8 bits -> 0xFE
    apply(2'b10, 2'b10, 2'b10, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_00FE, "R6 trunc");
    // R7 16-bit dest of signed 8x8 negative -> 0xFFFF only
    apply(2'b00, 2'b00, 2'b00, 2'b01, 32'hFF, 32'h01, 32'h0000_FFFF, "R7 clear");
    // R2 junk above width ignored
    apply(2'b00, 2'b00, 2'b00, 2'b10, 32'hABCD_1280, 32'h5A5A_7780, 32'h40, "R2 ignore");
    // R8 reserved codes
    apply(2'b11, 2'b00, 2'b00, 2'b10, 32'h80, 32'h80, 32'd0, "R8 op");
    apply(2'b00, 2'b11, 2'b00, 2'b10, 32'h80, 32'h80, 32'd0, "R8 width");
    apply(2'b00, 2'b00, 2'b00, 2'b11, 32'h80, 32'h80, 32'd0, "R8 dest");

    // R9 hold with in_valid low and changing inputs
    apply(2'b10, 2'b10, 2'b10, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0,
          model(2'b10, 2'b10, 2'b10, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0), "R4 32x32");
    held = dest;
    src_a = 32'hFFFF_FFFF; src_b = 32'h7; op_sel = 2'b00;
    @(negedge clk);
    check(dest === held && out_valid === 1'b0, "R9 hold", dest, held);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] op, wa, wb, wd;
      logic [31:0] a, b;
      op = 2'($urandom_range(0, 15) == 0 ? 3 : $urandom_range(0, 2));
      wa = 2'($urandom_range(0, 15) == 0 ? 3 : $urandom_range(0, 2));
      wb = 2'($urandom_range(0, 2));
      wd = 2'($urandom_range(0, 15) == 0 ? 3 : $urandom_range(0, 2));
      a = $urandom; b = $urandom;
      apply(op, wa, wb, wd, a, b, model(op, wa, wb, wd, a, b), "R3 R4 R5 R6 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule